// File: doc/BRIEF.md
# Soft Mute Volume Ramp with Fixed Gain Steps

This block sits in the PCM path ahead of a PWM modulator and conditions three 24-bit signed audio channels. All three channels get the same coarse gain, chosen once per reset from two configuration pins, with four choices from 0 dB to +18 dB in 6 dB steps. Each gain step is a left shift with saturation to the 24-bit range.

A second stage scales the gained samples by an attenuation index that runs from 0 (silence) to 1024 (unity). A mute request moves the index toward 0 and its release moves it back toward 1024, one unit at a time. The index is paced by a frame strobe, and the number of frames per unit depends on the sample-rate class reported by an upstream rate detector. When the index rests at zero the outputs are exactly zero, which the modulator turns into a 50% duty cycle. The coarse gain is never touched by muting, so unmuting returns to the gain chosen at reset.

Top module: `mute_ramp_gain`

## Requirements
- R1: While `rst_n` is low, every output sample is zero and the attenuation index is held at 0 (full attenuation).
- R2: Gain code `gain_pins` 2'b00, 2'b01, 2'b10, 2'b11 multiplies every channel by 1, 2, 4, 8 (left shift by 0..3 bits).
- R3: A gained sample above 8388607 becomes 8388607, and one below -8388608 becomes -8388608.
- R4: `gain_pins` is sampled at the first rising clock edge after `rst_n` goes high. Later changes have no effect until the next reset.
- R5: The index moves one unit per 4 frame strobes for `rate_cls` 0, per 8 for `rate_cls` 1, and per 16 for `rate_cls` 2 or 3. The strobe count restarts from zero whenever the index rests at its target.
- R6: Each channel output equals floor(gained_sample * index / 1024), with the index in 0..1024. A full ramp spans 1024 units.
- R7: With `mute_n` low the index heads to 0. With `mute_n` high it heads to 1024 and the reset-time gain is restored.
- R8: Reversing `mute_n` mid-ramp continues from the current index, with no jump.
- R9: With the index at 0, the outputs are exactly zero for any input.
- R10: `ramp_busy` is high exactly when the index differs from the target implied by the present `mute_n`.
- R11: Outputs are registered: a sample on `pcm_in` at a clock edge appears on `pcm_out` after that edge.
- R12: The index changes only at an edge where `frame_stb` is high, and by at most one unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gain_pins | input | 2 | Coarse gain select, captured after reset |
| mute_n | input | 1 | Active-low mute request |
| frame_stb | input | 1 | One-cycle pulse per audio frame |
| rate_cls | input | 2 | Sample-rate class: 0 up to 48 kHz, 1 double rate, 2/3 quad rate |
| pcm_in | input | 72 | Three signed 24-bit samples, channel 0 in the low bits |
| pcm_out | output | 72 | Three scaled signed 24-bit samples |
| ramp_busy | output | 1 | Index is moving toward its target |

## Verification
Random samples on all three channels run through full ramps up and down under every rate class. The strobe rate is varied between every cycle and every third cycle, which separates the per-strobe pacing from per-cycle pacing. Ramp lengths of 4096, 8192 and 16384 busy cycles show that the rate classes select the right step interval. A mute that is released after 2000 cycles must take exactly 2000 cycles to recover, which shows the reversal continues from the current index rather than restarting. Directed full-scale positive and negative samples at each gain code tell apart correct shifting, saturation, and the gain pins that are ignored after reset.

// File: rtl/smr_pkg.sv
package smr_pkg;

    typedef enum logic [1:0] {
        RATE_SINGLE = 2'd0,
        RATE_DOUBLE = 2'd1,
        RATE_QUAD   = 2'd2,
        RATE_QUAD_X = 2'd3
    } rate_cls_e;

    typedef enum logic [1:0] {
        GAIN_X1 = 2'd0,
        GAIN_X2 = 2'd1,
        GAIN_X4 = 2'd2,
        GAIN_X8 = 2'd3
    } gain_code_e;

    // extra log2 frames per step above the base pace, per rate class
    function automatic int unsigned pace_shift(input logic [1:0] cls);
        case (rate_cls_e'(cls))
            RATE_SINGLE: return 0;
            RATE_DOUBLE: return 1;
            default:     return 2;
        endcase
    endfunction

endpackage

// File: rtl/smr_gain_latch.sv
module smr_gain_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] gain_pins,
    output logic [1:0] gain_o,
    output logic       armed_o
);
    import smr_pkg::*;

    typedef struct packed {
        logic       armed;
        gain_code_e lvl;
    } gl_state_t;

    gl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.armed) begin
            st_d.lvl   = gain_code_e'(gain_pins);
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{armed: 1'b0, lvl: GAIN_X1};
        end else begin
            st_q <= st_d;
        end
    end

    assign gain_o  = st_q.lvl;
    assign armed_o = st_q.armed;

endmodule

// File: rtl/smr_ramp_ctrl.sv
module smr_ramp_ctrl #(
    parameter int RAMP_LOG2      = 10,
    parameter int PACE_BASE_LOG2 = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mute_n,
    input  logic                 frame_stb,
    input  logic [1:0]           rate_cls,
    output logic [RAMP_LOG2:0]   idx_o,
    output logic                 busy_o
);
    import smr_pkg::*;

    localparam int IDX_W      = RAMP_LOG2 + 1;
    localparam int CNT_W      = PACE_BASE_LOG2 + 2;
    localparam int RAMP_STEPS = 1 << RAMP_LOG2;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } rc_state_t;

    rc_state_t        st_d, st_q;
    logic [IDX_W-1:0] target;
    logic [CNT_W-1:0] last_cnt;
    logic             moving;

    always_comb begin
        target   = mute_n ? IDX_W'(RAMP_STEPS) : '0;
        last_cnt = CNT_W'((1 << (PACE_BASE_LOG2 + pace_shift(rate_cls))) - 1);
        moving   = (st_q.idx != target);
        st_d     = st_q;
        if (!moving) begin
            st_d.cnt = '0;
        end else if (frame_stb) begin
            if (st_q.cnt >= last_cnt) begin
                st_d.cnt = '0;
                if (target > st_q.idx) begin
                    st_d.idx = st_q.idx + 1'b1;
                end else begin
                    st_d.idx = st_q.idx - 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o  = st_q.idx;
    assign busy_o = moving;

endmodule

// File: rtl/smr_chan_scale.sv
module smr_chan_scale #(
    parameter int DW             = 24,
    parameter int RAMP_LOG2      = 10,
    parameter int GAIN_MAX_SHIFT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       smp_i,
    input  logic [1:0]          gain_i,
    input  logic [RAMP_LOG2:0]  idx_i,
    output logic [DW-1:0]       smp_o
);
    localparam int EW = DW + GAIN_MAX_SHIFT;
    localparam int PW = DW + RAMP_LOG2 + 1;

    localparam logic signed [EW-1:0] HI_LIM = {{(GAIN_MAX_SHIFT + 1){1'b0}}, {(DW - 1){1'b1}}};
    localparam logic signed [EW-1:0] LO_LIM = {{(GAIN_MAX_SHIFT + 1){1'b1}}, {(DW - 1){1'b0}}};

    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] shl;
    logic signed [DW-1:0] clip;
    logic signed [PW-1:0] prod;
    logic        [DW-1:0] out_d, out_q;

    always_comb begin
        ext = {{GAIN_MAX_SHIFT{smp_i[DW-1]}}, smp_i};
        shl = ext <<< gain_i;
        if (shl > HI_LIM) begin
            clip = {1'b0, {(DW - 1){1'b1}}};
        end else if (shl < LO_LIM) begin
            clip = {1'b1, {(DW - 1){1'b0}}};
        end else begin
            clip = shl[DW-1:0];
        end
        prod  = clip * $signed({1'b0, idx_i});
        out_d = DW'(prod >>> RAMP_LOG2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign smp_o = out_q;

endmodule

// File: rtl/mute_ramp_gain.sv
module mute_ramp_gain #(
    parameter int DW             = 24,
    parameter int NCH            = 3,
    parameter int RAMP_LOG2      = 10,
    parameter int PACE_BASE_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        gain_pins,
    input  logic              mute_n,
    input  logic              frame_stb,
    input  logic [1:0]        rate_cls,
    input  logic [NCH*DW-1:0] pcm_in,
    output logic [NCH*DW-1:0] pcm_out,
    output logic              ramp_busy
);
    localparam int IDX_W = RAMP_LOG2 + 1;

    logic [1:0]       gain_lvl;
    logic             gain_armed;
    logic [IDX_W-1:0] ramp_idx;

    smr_gain_latch u_gain (
        .clk       (clk),
        .rst_n     (rst_n),
        .gain_pins (gain_pins),
        .gain_o    (gain_lvl),
        .armed_o   (gain_armed)
    );

    smr_ramp_ctrl #(
        .RAMP_LOG2      (RAMP_LOG2),
        .PACE_BASE_LOG2 (PACE_BASE_LOG2)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .mute_n    (mute_n),
        .frame_stb (frame_stb),
        .rate_cls  (rate_cls),
        .idx_o     (ramp_idx),
        .busy_o    (ramp_busy)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        smr_chan_scale #(
            .DW        (DW),
            .RAMP_LOG2 (RAMP_LOG2)
        ) u_scale (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp_i  (pcm_in[ch*DW +: DW]),
            .gain_i (gain_lvl),
            .idx_i  (ramp_idx),
            .smp_o  (pcm_out[ch*DW +: DW])
        );
    end

endmodule

// File: rtl/mute_ramp_gain_chk.sv
module mute_ramp_gain_chk #(
    parameter int DW        = 24,
    parameter int NCH       = 3,
    parameter int RAMP_LOG2 = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mute_n,
    input logic                 frame_stb,
    input logic [RAMP_LOG2:0]   idx,
    input logic [1:0]           gain,
    input logic                 armed,
    input logic [NCH*DW-1:0]    pcm_out,
    input logic                 ramp_busy
);
    localparam int RAMP_STEPS = 1 << RAMP_LOG2;

    a_r6_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= (RAMP_LOG2 + 1)'(RAMP_STEPS));

    a_r12_hold_without_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(idx));

    a_r12_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (idx == $past(idx) || idx == $past(idx) + 1'b1 || idx == $past(idx) - 1'b1));

    a_r7_fall_when_muted: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute_n && frame_stb) |=> (idx <= $past(idx)));

    a_r7_rise_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_n && frame_stb) |=> (idx >= $past(idx)));

    a_r4_gain_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> $stable(gain));

    a_r9_silent_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == '0) |=> (pcm_out == '0));

    a_r10_idle_at_unity: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_n && idx == (RAMP_LOG2 + 1)'(RAMP_STEPS)) |-> !ramp_busy);

endmodule

bind mute_ramp_gain mute_ramp_gain_chk #(
    .DW        (DW),
    .NCH       (NCH),
    .RAMP_LOG2 (RAMP_LOG2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mute_n    (mute_n),
    .frame_stb (frame_stb),
    .idx       (ramp_idx),
    .gain      (gain_lvl),
    .armed     (gain_armed),
    .pcm_out   (pcm_out),
    .ramp_busy (ramp_busy)
);

// File: tb/tb_mute_ramp_gain.sv
module tb_mute_ramp_gain;
    localparam int DW    = 24;
    localparam int NCH   = 3;
    localparam int STEPS = 1024;
    localparam int W     = NCH * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    gain_pins = 2'b00;
    logic          mute_n = 1'b0;
    logic          frame_stb = 1'b0;
    logic [1:0]    rate_cls = 2'd0;
    logic [W-1:0]  pcm_in = '0;
    logic [W-1:0]  pcm_out;
    logic          ramp_busy;

    always #2 clk = ~clk;

    mute_ramp_gain dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .gain_pins (gain_pins),
        .mute_n    (mute_n),
        .frame_stb (frame_stb),
        .rate_cls  (rate_cls),
        .pcm_in    (pcm_in),
        .pcm_out   (pcm_out),
        .ramp_busy (ramp_busy)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    bit rand_en = 1;
    int stb_div = 1;
    int cyc = 0;

    // behavioural reference state
    int           idx_m = 0;
    int           cnt_m = 0;
    int           gain_m = 0;
    bit           armed_m = 0;
    logic [W-1:0] exp_out = '0;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] ref_scale(input logic [DW-1:0] s, input int g, input int idx);
        longint v;
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (DW - 1)) - 1;
        lo = -(longint'(1) <<< (DW - 1));
        v = longint'($signed(s));
        v = v * (longint'(1) <<< g);
        if (v > hi) v = hi;
        if (v < lo) v = lo;
        v = v * idx;
        v = v >>> 10;
        return v[DW-1:0];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_m = 0; cnt_m = 0; gain_m = 0; armed_m = 0; exp_out = '0;
        end else begin
            int tgt;
            int lim;
            for (int ch = 0; ch < NCH; ch++)
                exp_out[ch*DW +: DW] = ref_scale(pcm_in[ch*DW +: DW], gain_m, idx_m);
            if (!armed_m) begin
                gain_m = int'(gain_pins);
                armed_m = 1;
            end
            tgt = mute_n ? STEPS : 0;
            lim = (rate_cls == 2'd0) ? 4 : (rate_cls == 2'd1) ? 8 : 16;
            if (idx_m == tgt) cnt_m = 0;
            else if (frame_stb) begin
                if (cnt_m >= lim - 1) begin
                    cnt_m = 0;
                    idx_m = (tgt > idx_m) ? idx_m + 1 : idx_m - 1;
                end else cnt_m = cnt_m + 1;
            end
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!done) begin
            bit busy_e;
            busy_e = (idx_m != (mute_n ? STEPS : 0));
            chk(pcm_out === exp_out, "R11 R6 per-cycle output", pcm_out, exp_out);
            chk(ramp_busy === busy_e, "R10 per-cycle busy", W'(ramp_busy), W'(busy_e));
        end
    end

    // frame strobe and random sample driver
    always @(posedge clk) begin
        #1;
        cyc++;
        frame_stb = ((cyc % stb_div) == 0);
        if (rand_en)
            for (int ch = 0; ch < NCH; ch++) pcm_in[ch*DW +: DW] = DW'($urandom);
    end

    task automatic apply_reset(input logic [1:0] g);
        @(posedge clk); #1;
        rst_n = 1'b0; gain_pins = g; mute_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(pcm_out == '0, "R1 outputs zero in reset", pcm_out, '0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        gain_pins = ~g;
    endtask

    task automatic measure(output int n);
        n = 0;
        @(negedge clk);
        while (ramp_busy && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic steady(input logic [DW-1:0] v, input logic [DW-1:0] e, input string tag);
        @(posedge clk); #1;
        rand_en = 0;
        pcm_in = {NCH{v}};
        @(posedge clk);
        @(negedge clk);
        chk(pcm_out == {NCH{e}}, tag, pcm_out, {NCH{e}});
        rand_en = 1;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        apply_reset(2'b10);
        @(posedge clk); #1;
        mute_n = 1'b1;
        measure(n);
        chk(n == 4096, "R5 R6 class0 ramp length", W'(n), W'(4096));
        steady(24'd1000, 24'd4000, "R4 R2 gain from reset pins");
        chk(ramp_busy == 1'b0, "R10 idle at unity", W'(ramp_busy), '0);
        steady(24'h300000, 24'h7FFFFF, "R3 positive clamp");
        steady(24'hD00000, 24'h800000, "R3 negative clamp");

        rate_cls = 2'd1;
        @(posedge clk); #1;
        mute_n = 1'b0;
        repeat (2000) @(posedge clk);
        #1;
        mute_n = 1'b1;
        measure(n);
        chk(n == 2000, "R8 reversal resumes from index", W'(n), W'(2000));

        @(posedge clk); #1;
        mute_n = 1'b0;
        measure(n);
        chk(n == 8192, "R5 R7 class1 mute length", W'(n), W'(8192));
        steady(24'h7FFFFF, 24'h000000, "R9 silent when muted");

        rate_cls = 2'd2;
        @(posedge clk); #1;
        mute_n = 1'b1;
        measure(n);
        chk(n == 16384, "R5 class2 ramp length", W'(n), W'(16384));
        steady(24'd1000, 24'd4000, "R7 prior gain restored");

        rate_cls = 2'd3;
        stb_div = 3;
        @(posedge clk); #1;
        mute_n = 1'b0;
        measure(n);
        steady(24'h800000, 24'h000000, "R9 R12 sparse strobes reach silence");
        stb_div = 1;
        rate_cls = 2'd0;

        apply_reset(2'b00);
        @(posedge clk); #1;
        rand_en = 0;
        pcm_in = {NCH{24'd1000}};
        mute_n = 1'b1;
        repeat (2048) @(posedge clk);
        @(negedge clk);
        chk(pcm_out == {NCH{24'd499}}, "R6 mid-ramp scaling", pcm_out, {NCH{24'd499}});
        rand_en = 1;
        measure(n);
        steady(24'd1000, 24'd1000, "R2 code 00");

        apply_reset(2'b01);
        @(posedge clk); #1;
        mute_n = 1'b1;
        measure(n);
        steady(24'd1000, 24'd2000, "R2 code 01");

        apply_reset(2'b11);
        @(posedge clk); #1;
        mute_n = 1'b1;
        measure(n);
        steady(24'd1000, 24'd8000, "R2 code 11");
        steady(24'h100001, 24'h7FFFFF, "R3 clamp at x8");
        steady(24'hF00000, 24'h800000, "R3 negative full scale at x8");

        repeat (4) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule